// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general register storage of a 32-bit processor core whose register view changes with the processor mode. Software always names sixteen logical registers. The block selects the physical storage for each name from the current mode. A few names are private to the fast-interrupt mode, the stack and link names are private to each exception mode, and the remaining names are shared by every mode. Two combinational read ports and one clocked write port serve the execute stage. All three ports see the mode on the same `mode` input.

Each exception mode also owns one saved-status word. The saved-status word has its own read and write port and always refers to the current mode's copy. User and system modes have no saved-status word. An access made from one of those modes is refused, and a flag reports it. Incrementing the program counter and deciding when to change mode belong to the surrounding core.

Top module: `bank_regfile`

## Requirements
- R1: Logical indices 0 to 7 reach one physical register each, the same in every mode. Data written under one mode reads back under any other mode.
- R2: Logical indices 8 to 12 reach a private set only in fast-interrupt mode (mode code 1). All other modes share one common set for these indices.
- R3: Logical indices 13 and 14 reach a private pair in each of fast-interrupt (1), IRQ (2), supervisor (3), abort (4) and undefined (5) modes.
- R4: User mode (code 0) and system mode (code 6) share the same pair for indices 13 and 14.
- R5: Logical index 15 reaches one register shared by all modes.
- R6: Modes 1 to 5 each own one saved-status word. When such a mode is current, `sr_rd_data` shows that mode's word, and `sr_wr_en` writes it at the next rising edge. `sr_bad` stays 0 in these modes.
- R7: In modes 0, 6 or 7, `sr_rd_data` reads zero and a saved-status write changes nothing. `sr_bad` is 1 whenever `sr_rd_en` or `sr_wr_en` is set in these modes.
- R8: Reads are combinational. A general write lands at the rising edge. A read of the register being written in the same cycle returns the previous value.
- R9: Mode code 7 is unassigned and reaches the user/system bank.
- R10: Reset (active-low, asynchronous) clears every general and saved-status register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes land on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Current mode: 0 user, 1 fast-interrupt, 2 IRQ, 3 supervisor, 4 abort, 5 undefined, 6 system, 7 unassigned |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | General write data |
| sr_rd_en | input | 1 | Saved-status read request; used only for the invalid flag |
| sr_wr_en | input | 1 | Saved-status write enable |
| sr_wr_data | input | 32 | Saved-status write data |
| sr_rd_data | output | 32 | Saved-status word of the current mode, or zero |
| sr_bad | output | 1 | Saved-status access made in a mode that has no such word |

## Verification
A wrong bank selection does not show up when the write happens. It shows up only when the same logical index is read later under a different mode. The bench therefore writes a distinct value to every index in every mode before reading each index back under all eight mode codes. A stray saved-status write from user or system mode is silent at the time it is made. It shows up when the exception modes read their words back after the refused writes. Read-before-write behaviour is visible in the same cycle as the write, on a read port aimed at the register being written.

// File: rtl/bank_rf_pkg.sv
`timescale 1ns/1ps
package bank_rf_pkg;
  localparam int unsigned IDX_W     = 4;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned N_LOW     = 8;   // shared low names
  localparam int unsigned N_HIGH    = 5;   // names with a fast-mode copy
  localparam int unsigned N_STKBANK = 6;   // sp/lr pairs
  localparam int unsigned BANK_BASE = N_LOW + 2 * N_HIGH;
  localparam int unsigned N_GPR     = BANK_BASE + 2 * N_STKBANK + 1;
  localparam int unsigned PC_PHYS   = N_GPR - 1;
  localparam int unsigned N_SR      = 5;
  localparam int unsigned PHYS_W    = $clog2(N_GPR);
  localparam int unsigned SR_W      = $clog2(N_SR);

  typedef enum logic [MODE_W-1:0] {
    MD_USER   = 3'd0,
    MD_FAST   = 3'd1,
    MD_IRQ    = 3'd2,
    MD_SVC    = 3'd3,
    MD_ABORT  = 3'd4,
    MD_UNDEF  = 3'd5,
    MD_SYSTEM = 3'd6,
    MD_RESV   = 3'd7
  } mode_e;

  // which sp/lr pair a mode uses; 0 is the user/system pair
  function automatic logic [2:0] stack_bank(input logic [MODE_W-1:0] m);
    case (m)
      MD_SVC:   return 3'd1;
      MD_ABORT: return 3'd2;
      MD_UNDEF: return 3'd3;
      MD_IRQ:   return 3'd4;
      MD_FAST:  return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic logic [PHYS_W-1:0] phys_of(input logic [MODE_W-1:0] m,
                                                input logic [IDX_W-1:0] idx);
    logic [PHYS_W-1:0] p;
    if (idx < IDX_W'(N_LOW))
      p = PHYS_W'(idx);
    else if (idx < IDX_W'(N_LOW + N_HIGH))
      p = (m == MD_FAST) ? PHYS_W'(idx) + PHYS_W'(N_HIGH) : PHYS_W'(idx);
    else if (idx < IDX_W'(15))
      p = PHYS_W'(BANK_BASE) + PHYS_W'({stack_bank(m), 1'b0})
        + PHYS_W'(idx - IDX_W'(13));
    else
      p = PHYS_W'(PC_PHYS);
    return p;
  endfunction

  function automatic logic sr_present(input logic [MODE_W-1:0] m);
    return (m == MD_FAST) || (m == MD_IRQ) || (m == MD_SVC) ||
           (m == MD_ABORT) || (m == MD_UNDEF);
  endfunction

  function automatic logic [SR_W-1:0] sr_slot(input logic [MODE_W-1:0] m);
    case (m)
      MD_FAST:  return SR_W'(0);
      MD_IRQ:   return SR_W'(1);
      MD_SVC:   return SR_W'(2);
      MD_ABORT: return SR_W'(3);
      MD_UNDEF: return SR_W'(4);
      default:  return SR_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/bank_rf_map.sv
`timescale 1ns/1ps
module bank_rf_map
  import bank_rf_pkg::*;
#(
  parameter int unsigned N_PORT = 3
) (
  input  logic [MODE_W-1:0]              mode,
  input  logic [N_PORT-1:0][IDX_W-1:0]   idx,
  output logic [N_PORT-1:0][PHYS_W-1:0]  phys,
  output logic                           sr_ok,
  output logic [SR_W-1:0]                sr_sel
);
  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    assign phys[p] = phys_of(mode, idx[p]);
  end

  assign sr_ok  = sr_present(mode);
  assign sr_sel = sr_slot(mode);
endmodule

// File: rtl/bank_rf_gpr.sv
`timescale 1ns/1ps
module bank_rf_gpr #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned N_RD   = 2,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [N_RD-1:0][AW-1:0]       rd_addr,
  output logic [N_RD-1:0][DATA_W-1:0]   rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(DEPTH); k++) mem[k] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rd_data[r] = mem[rd_addr[r]];
  end
endmodule

// File: rtl/bank_rf_sr.sv
`timescale 1ns/1ps
module bank_rf_sr #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_ok,
  input  logic [AW-1:0]     slot,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              bad,
  output logic              wr_fire
);
  logic [DATA_W-1:0] word [DEPTH];

  assign wr_fire = wr_en & slot_ok;
  assign bad     = (rd_en | wr_en) & ~slot_ok;
  assign rd_data = slot_ok ? word[slot] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(DEPTH); k++) word[k] <= '0;
    end else if (wr_fire) begin
      word[slot] <= wr_data;
    end
  end
endmodule

// File: rtl/bank_regfile.sv
`timescale 1ns/1ps
module bank_regfile
  import bank_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sr_rd_en,
  input  logic              sr_wr_en,
  input  logic [DATA_W-1:0] sr_wr_data,
  output logic [DATA_W-1:0] sr_rd_data,
  output logic              sr_bad
);
  localparam int unsigned N_RD   = 2;
  localparam int unsigned N_PORT = N_RD + 1;   // reads first, write last

  // named internal events, observed by the bound checker
  logic [N_PORT-1:0][IDX_W-1:0]  port_idx;
  logic [N_PORT-1:0][PHYS_W-1:0] port_phys;
  logic [N_RD-1:0][PHYS_W-1:0]   rd_phys;
  logic [N_RD-1:0][DATA_W-1:0]   rd_word;
  logic [PHYS_W-1:0]             wr_phys;
  logic                          sr_ok;
  logic [SR_W-1:0]               sr_sel;
  logic                          sr_wr_fire;

  assign port_idx = {wr_idx, rd_b_idx, rd_a_idx};

  bank_rf_map #(.N_PORT(N_PORT)) u_map (
    .mode   (mode),
    .idx    (port_idx),
    .phys   (port_phys),
    .sr_ok  (sr_ok),
    .sr_sel (sr_sel)
  );

  assign rd_phys = port_phys[N_RD-1:0];
  assign wr_phys = port_phys[N_RD];

  bank_rf_gpr #(.DATA_W(DATA_W), .DEPTH(N_GPR), .N_RD(N_RD), .AW(PHYS_W)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_phys),
    .wr_data (wr_data),
    .rd_addr (rd_phys),
    .rd_data (rd_word)
  );

  assign rd_a_data = rd_word[0];
  assign rd_b_data = rd_word[1];

  bank_rf_sr #(.DATA_W(DATA_W), .DEPTH(N_SR), .AW(SR_W)) u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_ok (sr_ok),
    .slot    (sr_sel),
    .rd_en   (sr_rd_en),
    .wr_en   (sr_wr_en),
    .wr_data (sr_wr_data),
    .rd_data (sr_rd_data),
    .bad     (sr_bad),
    .wr_fire (sr_wr_fire)
  );
endmodule

// File: rtl/bank_rf_chk.sv
`timescale 1ns/1ps
module bank_rf_chk
  import bank_rf_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              sr_rd_en,
  input logic              sr_wr_en,
  input logic [DATA_W-1:0] sr_rd_data,
  input logic              sr_bad,
  input logic              sr_wr_fire
);
  logic no_sr_mode;
  assign no_sr_mode = (mode == MD_USER) || (mode == MD_SYSTEM) || (mode == MD_RESV);

  AST_BAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sr_bad |-> (sr_rd_data == '0)); // R7

  AST_BAD_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sr_bad |-> !sr_wr_fire); // R7

  AST_FLAG_MATCHES_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd_en || sr_wr_en) |-> (sr_bad == no_sr_mode)); // R6

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_a_idx != $past(wr_idx)) || (mode != $past(mode)) ||
               (rd_a_data == $past(wr_data)))); // R8

  AST_LOW_MODE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && (rd_a_idx < 4'd8) && (rd_a_idx == $past(rd_a_idx)))
      |-> $stable(rd_a_data)); // R1

  AST_PC_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && (rd_a_idx == 4'd15) && ($past(rd_a_idx) == 4'd15))
      |-> $stable(rd_a_data)); // R5
endmodule

bind bank_regfile bank_rf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, sr_rd_en = 1'b0, sr_wr_en = 1'b0;
  logic [31:0] sr_wr_data = '0, sr_rd_data;
  logic        sr_bad;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bank_regfile u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sr_rd_en(sr_rd_en), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
    .sr_rd_data(sr_rd_data), .sr_bad(sr_bad)
  );

  // reference model, laid out by architectural role
  logic [31:0] m_low [8];
  logic [31:0] m_com [5];
  logic [31:0] m_fast[5];
  logic [31:0] m_stk [6][2];
  logic [31:0] m_pc;
  logic [31:0] m_sr  [8];   // indexed directly by mode code

  function automatic int pair_of(int md);
    case (md)
      1: return 5; 2: return 4; 3: return 1; 4: return 2; 5: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic bit has_sr(int md);
    return (md >= 1) && (md <= 5);
  endfunction

  function automatic logic [31:0] mread(int md, int i);
    if (i < 8) return m_low[i];
    if (i < 13) return (md == 1) ? m_fast[i-8] : m_com[i-8];
    if (i < 15) return m_stk[pair_of(md)][i-13];
    return m_pc;
  endfunction

  task automatic mwrite(int md, int i, logic [31:0] v);
    if (i < 8) m_low[i] = v;
    else if (i < 13) begin
      if (md == 1) m_fast[i-8] = v; else m_com[i-8] = v;
    end else if (i < 15) m_stk[pair_of(md)][i-13] = v;
    else m_pc = v;
  endtask

  function automatic string tag_of(int md, int i);
    if (md == 7 && i >= 8) return "R9";
    if (i < 8) return "R1";
    if (i < 13) return "R2";
    if (i < 15) return (md == 6 || md == 0) ? "R4" : "R3";
    return "R5";
  endfunction

  typedef struct {
    bit          do_g;
    bit          do_s;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] s;
    logic        bad;
    string       ta;
    string       tb;
    string       ts;
  } item_t;

  item_t q[$];

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected results pushed to the scoreboard
  task automatic step(int md, int ia, int ib, bit we, int wi, logic [31:0] wd,
                      bit sre, bit srw, logic [31:0] sd, bit cg, bit cs,
                      string ta, string tb, string ts);
    item_t it;
    @(negedge clk);
    mode = 3'(md); rd_a_idx = 4'(ia); rd_b_idx = 4'(ib);
    wr_en = we; wr_idx = 4'(wi); wr_data = wd;
    sr_rd_en = sre; sr_wr_en = srw; sr_wr_data = sd;
    it.do_g = cg; it.do_s = cs;
    it.a = mread(md, ia); it.b = mread(md, ib);
    it.s = has_sr(md) ? m_sr[md] : 32'h0;
    it.bad = (sre || srw) && !has_sr(md);
    it.ta = ta; it.tb = tb; it.ts = ts;
    if (cg || cs) q.push_back(it);
    if (we) mwrite(md, wi, wd);
    if (srw && has_sr(md)) m_sr[md] = sd;
  endtask

  // monitor: compares between edges
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        it = q.pop_front();
        if (it.do_g) begin
          check(rd_a_data, it.a, it.ta, "port A");
          check(rd_b_data, it.b, it.tb, "port B");
        end
        if (it.do_s) begin
          check(sr_rd_data, it.s, it.ts, "saved status");
          check({31'b0, sr_bad}, {31'b0, it.bad}, it.ts, "invalid flag");
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] pat(int md, int i);
    return {8'h5A, 8'(md), 8'(i), 8'hC3};
  endfunction

  initial begin
    int order[8];
    for (int i = 0; i < 8; i++) m_low[i] = '0;
    for (int i = 0; i < 5; i++) begin m_com[i] = '0; m_fast[i] = '0; end
    for (int b = 0; b < 6; b++) begin m_stk[b][0] = '0; m_stk[b][1] = '0; end
    for (int md = 0; md < 8; md++) m_sr[md] = '0;
    m_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: everything zero after reset
    for (int i = 0; i < 8; i++)
      step(0, i, i + 8, 0, 0, 0, 0, 0, 0, 1, 0, "R10", "R10", "");
    for (int md = 1; md < 6; md++)
      step(md, 13, 14, 0, 0, 0, 1, 0, 0, 1, 1, "R10", "R10", "R10");

    // fill every index in every mode; port A reads the target (R8: old value)
    order = '{7, 0, 1, 2, 3, 4, 5, 6};
    foreach (order[k]) begin
      for (int i = 0; i < 16; i++)
        step(order[k], i, (i + 5) % 16, 1, i, pat(order[k], i), 0, 0, 0, 1, 0,
             "R8", tag_of(order[k], (i + 5) % 16), "");
    end

    // read everything back under all eight mode codes
    for (int md = 0; md < 8; md++)
      for (int i = 0; i < 8; i++)
        step(md, i, i + 8, 0, 0, 0, 0, 0, 0, 1, 0, tag_of(md, i), tag_of(md, i + 8), "");

    // R9: unassigned code writes land in the user/system pair
    step(7, 0, 0, 1, 13, 32'h7777_0013, 0, 0, 0, 0, 0, "", "", "");
    step(0, 13, 14, 0, 0, 0, 0, 0, 0, 1, 0, "R9", "R9", "");
    step(3, 13, 14, 0, 0, 0, 0, 0, 0, 1, 0, "R9", "R9", "");
    step(0, 0, 0, 1, 14, 32'h0000_E014, 0, 0, 0, 0, 0, "", "", "");
    step(7, 14, 12, 0, 0, 0, 0, 0, 0, 1, 0, "R9", "R9", "");

    // R6: each exception mode writes its saved word (same-cycle read is old)
    for (int md = 1; md < 6; md++)
      step(md, 0, 15, 0, 0, 0, 1, 1, 32'h5E00_0000 | 32'(md), 0, 1, "", "", "R6");
    for (int md = 0; md < 8; md++)
      step(md, 0, 15, 0, 0, 0, 1, 0, 0, 1, 1, "R1", "R5", has_sr(md) ? "R6" : "R7");

    // R7: refused writes from modes without a saved word
    step(0, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD_BEEF, 0, 1, "", "", "R7");
    step(6, 0, 0, 0, 0, 0, 0, 1, 32'hBAD0_0006, 0, 1, "", "", "R7");
    step(7, 0, 0, 0, 0, 0, 1, 1, 32'hBAD0_0007, 0, 1, "", "", "R7");
    for (int md = 1; md < 6; md++)
      step(md, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "", "", "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "", "", "R7");

    @(negedge clk);
    #5;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule